// File: doc/BRIEF.md
# Buffered Three-Channel PWM Timer

This block is a 16-bit up-counter that drives three edge-aligned PWM outputs from one shared period. Four compare values control it: slot 0 holds the period, and slots 1 to 3 hold the duty of outputs 0 to 2. Software writes these values through a plain write port into staging registers. The counter and the comparators never read the staging registers. They read a set of active registers.

Staged values move into the active set at two points only. The first is when counting is enabled. The second is a counter clear that follows a commit. A commit is a write to slot 1, the duty of output 0, and it moves all four values at once. To change several values, software writes slots 0, 2 and 3 first and then writes slot 1 last. Slot 1 must be written even when its value does not change. A 3-bit select chooses a power-of-two prescaler that sets the counting rate.

Top module: `pwm3_buffered`

## Requirements
- R1: While reset is asserted and after it is released with `en` low, all three bits of `pwm_out` are 0.
- R2: A write with `wr_en` high stores `wr_data` in staging slot `wr_addr`: 0 is the period, and 1, 2 and 3 are the duty of `pwm_out[0]`, `pwm_out[1]` and `pwm_out[2]`.
- R3: On the first clock edge where `en` is sampled high, the staged values are copied into the active set and the counter starts at 0. On every edge where `en` is sampled low, counting stops and all outputs are 0 after that edge.
- R4: On each count tick the counter advances from 0 up to the active period P and then clears to 0, so one PWM cycle lasts P+1 ticks.
- R5: `pwm_out[k]` is high while the counter is below the active duty of its channel. A duty of 0 gives a constant low output, and a duty greater than P gives a constant high output.
- R6: Writes to slots 0, 2 and 3 without a following write to slot 1 leave the active period and duties unchanged.
- R7: A write to slot 1 arms a transfer. At the next counter clear, all four staged values become active together and the arm is dropped. A write to slot 1 alone changes only the duty of output 0.
- R8: A slot-1 write in the same cycle as a counter clear does not commit at that clear. That clear keeps the old values, and the transfer happens at the following clear.
- R9: With `clk_sel` = n (0 to 7), a count tick occurs every 2^n clock cycles. Each counter value therefore holds for 2^n cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counting enable |
| clk_sel | input | 3 | Prescaler select, divides by 2^clk_sel |
| wr_en | input | 1 | Write strobe for the staging slots |
| wr_addr | input | 2 | Staging slot index |
| wr_data | input | 16 | Value to write |
| pwm_out | output | 3 | PWM outputs, one per duty channel |

## Verification
A commit write to slot 1 and a counter clear can land on the same clock edge. The bench provokes this from the output waveform. It finds the falling edge of output 0, counts forward to the sample where the counter holds the period value, and issues the slot-1 write there. It then measures two full cycles between rising edges. The first must still show the old period and duty, and the second must show the new ones.

// File: rtl/pwm3_buffered.sv
module pwm3_buffered #(
  parameter int CW   = 16,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] clk_sel,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic [2:0]      pwm_out
);
  localparam int PSW = (1 << SELW) - 1;

  logic [3:0][CW-1:0] stg;
  logic [3:0][CW-1:0] act;
  logic [CW-1:0]      cnt;
  logic [PSW-1:0]     pre_cnt;
  logic               armed;
  logic               run_q;

  wire [PSW-1:0] pre_mask = ~({PSW{1'b1}} << clk_sel);
  wire           tick     = run_q && ((pre_cnt & pre_mask) == pre_mask);
  wire           wrap     = tick && (cnt >= act[0]);
  wire           commit   = wr_en && (wr_addr == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (wr_en) begin
      stg[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt     <= '0;
      pre_cnt <= '0;
      act     <= '0;
      armed   <= 1'b0;
    end else begin
      run_q <= en;
      if (!en) begin
        cnt     <= '0;
        pre_cnt <= '0;
        armed   <= armed | commit;
      end else if (!run_q) begin
        cnt     <= '0;
        pre_cnt <= '0;
        act     <= stg;
        armed   <= commit;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
        if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
        if (wrap && armed) begin
          act   <= stg;
          armed <= commit;
        end else begin
          armed <= armed | commit;
        end
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_cmp
    assign pwm_out[k] = run_q && (cnt < act[k+1]);
  end
endmodule

// File: rtl/pwm3_buffered_chk.sv
module pwm3_buffered_chk #(
  parameter int CW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [2:0]         pwm_out,
  input logic               run_q,
  input logic               armed,
  input logic [CW-1:0]      cnt,
  input logic [3:0][CW-1:0] act
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == 3'b000)); // R3

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !armed) |=> $stable(act)); // R6

  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> armed); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt <= act[0])); // R4

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act[1] == '0) |-> !pwm_out[0]); // R5
endmodule

bind pwm3_buffered pwm3_buffered_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
  .pwm_out(pwm_out), .run_q(run_q), .armed(armed), .cnt(cnt), .act(act)
);

// File: tb/pwm3_buffered_tb_top.sv
module pwm3_buffered_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  pwm_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [2:0] cur = '0, prv = '0;

  always #2 clk = ~clk;

  pwm3_buffered dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // period, duty0, duty1, duty2, sel, expected high cycles out0..out2
  localparam int NV = 4;
  localparam int VEC [NV][8] = '{
    '{ 9, 3, 0, 12, 0,  3,  0, 10},
    '{ 4, 4, 5,  1, 1,  8, 10,  2},
    '{15, 8, 16, 15, 2, 32, 64, 60},
    '{ 0, 1, 0,  1, 0,  1,  0,  1}
  };

  task automatic chk(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
    prv = cur;
    cur = pwm_out;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    do step(); while (!(!prv[0] && cur[0]));
  endtask

  task automatic wait_fall();
    do step(); while (!(prv[0] && !cur[0]));
  endtask

  task automatic measure(output int per, output int h0, output int h1);
    per = 0; h0 = 0; h1 = 0;
    do begin
      h0 += int'(cur[0]); h1 += int'(cur[1]); per++;
      step();
    end while (!(!prv[0] && cur[0]));
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int per, h0, h1;
    int hs [3];
    step();
    chk(pwm_out == 3'b000, "R1 reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    step(); step();
    chk(pwm_out == 3'b000, "R1 idle", int'(pwm_out), 0);

    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < 4; s++) wr(s, VEC[v][s]);
      clk_sel = 3'(VEC[v][4]);
      en = 1'b1;
      hs = '{0, 0, 0};
      for (int c = 0; c < ((VEC[v][0] + 1) << VEC[v][4]); c++) begin
        step();
        for (int k = 0; k < 3; k++) hs[k] += int'(cur[k]);
      end
      for (int k = 0; k < 3; k++)
        chk(hs[k] == VEC[v][5+k], "R2 R4 R5 R9 duty window", hs[k], VEC[v][5+k]);
      en = 1'b0;
      step();
      chk(cur == 3'b000, "R3 disable", int'(cur), 0);
      step();
    end

    clk_sel = '0;
    wr(0, 9); wr(1, 3); wr(2, 5); wr(3, 0);
    en = 1'b1;
    wait_rise();
    measure(per, h0, h1);
    chk(per == 10, "R3 R4 period", per, 10);
    chk(h0 == 3, "R5 duty0", h0, 3);

    wr(0, 5); wr(2, 2);
    wait_rise();
    measure(per, h0, h1);
    chk(per == 10, "R6 period held", per, 10);
    chk(h1 == 5, "R6 duty1 held", h1, 5);

    wr(1, 3);
    wait_rise();
    measure(per, h0, h1);
    chk(per == 6, "R7 period committed", per, 6);
    chk(h1 == 2, "R7 duty1 committed", h1, 2);

    wr(1, 2);
    wait_rise();
    measure(per, h0, h1);
    chk(per == 6, "R7 duty-only period", per, 6);
    chk(h0 == 2, "R7 duty-only out0", h0, 2);

    wr(0, 7);
    wait_fall();
    step(); step(); step();
    wr(1, 4);
    chk(!prv[0] && cur[0], "R8 clear on write edge", int'(cur[0]), 1);
    measure(per, h0, h1);
    chk(per == 6, "R8 old period kept", per, 6);
    chk(h0 == 2, "R8 old duty kept", h0, 2);
    measure(per, h0, h1);
    chk(per == 8, "R8 new period", per, 8);
    chk(h0 == 4, "R8 new duty", h0, 4);

    en = 1'b0;
    step();
    chk(cur == 3'b000, "R3 stop", int'(cur), 0);
    step(); step();
    chk(cur == 3'b000, "R3 stays low", int'(cur), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule